// File: doc/BRIEF.md
# Pair-Inverting Phase-Flagged Serial Link

This block turns parallel words into a single serial data line and reduces how often that line toggles. It needs no extra flag bit to do this. The transmitter counts the bit-to-bit changes inside each incoming word. When the count is high, it inverts the upper bit of every two-bit group. The choice between plain and inverted is carried only by timing. A coded word is launched half a bit period later than the bit clock, and a plain word is launched in line with it.

The whole block runs on one clock at twice the bit rate, so one bit period is two clock cycles. The half-period shift is a launch on the other phase of the fast clock. The receiver samples on every fast cycle. At each frame strobe it reads the level of the bit clock to learn which phase the word uses. It then collects the word and undoes the inversion when needed.

The input follows valid/ready rules. A word is taken in any cycle where `s_valid` and `s_ready` are both high. While `s_valid` is high and `s_ready` is low, the sender must hold `s_data` steady. `s_ready` rises only in the last slot of the word in flight, or when the link is idle. The output is a one-cycle `m_valid` strobe with no ready signal, because a serial line cannot be stalled.

Top module: `pinv_link`

## Requirements
- R1: A word is accepted in a cycle with `s_valid` and `s_ready` both high. `s_ready` is low in the cycle after an accept. When words are offered back to back, accepts happen exactly 2*WL cycles apart.
- R2: The transition count is the number of positions i, for 0 <= i < WL-1, where data bit i differs from bit i+1. A word is coded when this count is at least WL/2. Otherwise it is sent plain.
- R3: A plain word is sent on `line_o` least significant bit first, with every bit unchanged. Each bit first appears in a cycle where `bclk_o` is high.
- R4: In a coded word, the bits are grouped in pairs (2j, 2j+1). The odd-indexed bit of each pair is inverted on the line and the even-indexed bit is sent as is (mask 0xAA for WL=8).
- R5: Each bit of a coded word first appears in a cycle where `bclk_o` is low, half a bit period after the plain timing. A frame strobe seen with `bclk_o` low marks a coded word, and one seen with `bclk_o` high marks a plain word.
- R6: `frame_o` is high for exactly one cycle per word, together with the first appearance of bit 0. A word occupies exactly WL bit periods, with no added flag bit.
- R7: Bit k of a word is visible on the line 2k cycles after its frame strobe. The receiver outputs the decoded original word with a one-cycle `m_valid` pulse. `m_coded` is 1 for a coded word.
- R8: Any frame strobe restarts the receiver. A partly received word is dropped without producing an output, and no output follows in the cycle after a strobe.
- R9: While `rst_n` is low, `line_o`, `frame_o`, `bclk_o`, `m_valid`, `m_data` and `m_coded` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Input word ready |
| s_data | input | WL | Input word |
| line_o | output | 1 | Serial data out |
| bclk_o | output | 1 | Bit clock out (high in first half of a plain bit) |
| frame_o | output | 1 | One-cycle word start strobe |
| line_i | input | 1 | Serial data in |
| bclk_i | input | 1 | Bit clock in |
| frame_i | input | 1 | Word start strobe in |
| m_valid | output | 1 | Decoded word strobe |
| m_data | output | WL | Decoded word |
| m_coded | output | 1 | Received word was pair-inverted |

## Verification
The assertions check the following on every cycle:
- every line change sits on the bit-clock phase that matches the mode of its word;
- strobes last one cycle;
- `s_ready` falls after an accept;
- the receiver stays quiet right after a strobe.

The scenarios cover the rest. The threshold decision (including a count exactly equal to WL/2), the exact line pattern of each pair, and word-to-word mode changes in both directions only show up by replaying known words. The same holds for a coded word that leaves the line constant, and for a truncated frame that the receiver must drop.

// File: rtl/pinv_pkg.sv
package pinv_pkg;
  typedef enum logic {
    MODE_PLAIN   = 1'b0,
    MODE_PAIRINV = 1'b1
  } mode_e;
endpackage

// File: rtl/pinv_encoder.sv
module pinv_encoder
  import pinv_pkg::*;
#(
  parameter int WL = 8
) (
  input  logic [WL-1:0] raw,
  output logic [WL-1:0] enc,
  output mode_e         mode
);
  localparam int CNTW = $clog2(WL);
  localparam int TH   = WL / 2;

  logic [WL-1:0]   flip;
  logic [WL-2:0]   tog;
  logic [CNTW-1:0] cnt;

  for (genvar g = 0; g < WL; g++) begin : g_flip
    assign flip[g] = (g % 2 == 1);
  end
  for (genvar g = 0; g < WL - 1; g++) begin : g_tog
    assign tog[g] = raw[g] ^ raw[g+1];
  end

  always_comb begin
    cnt = '0;
    for (int i = 0; i < WL - 1; i++) cnt = cnt + CNTW'(tog[i]);
  end

  assign mode = (cnt >= CNTW'(TH)) ? MODE_PAIRINV : MODE_PLAIN;
  assign enc  = (mode == MODE_PAIRINV) ? (raw ^ flip) : raw;
endmodule

// File: rtl/pinv_serializer.sv
module pinv_serializer
  import pinv_pkg::*;
#(
  parameter int WL = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [WL-1:0] enc_i,
  input  mode_e         mode_i,
  output logic          bclk_o,
  output logic          line_o,
  output logic          frame_o
);
  localparam int SW = $clog2(2 * WL);
  localparam int IW = $clog2(WL);
  localparam logic [SW-1:0] LAST = SW'(2 * WL - 1);

  logic          act;
  logic [SW-1:0] sl;
  logic [WL-1:0] word_r;
  mode_e         md_r, lmode;
  logic          launch;
  logic [IW-1:0] bidx;

  assign s_ready = bclk_o && (!act || sl == LAST);
  assign bidx    = sl[SW-1:1];
  assign launch  = act && (sl[0] == (md_r == MODE_PAIRINV));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_o  <= 1'b0;
      act     <= 1'b0;
      sl      <= '0;
      word_r  <= '0;
      md_r    <= MODE_PLAIN;
      line_o  <= 1'b0;
      frame_o <= 1'b0;
      lmode   <= MODE_PLAIN;
    end else begin
      bclk_o  <= ~bclk_o;
      frame_o <= launch && (bidx == '0);
      if (launch) begin
        line_o <= word_r[bidx];
        lmode  <= md_r;
      end
      if (s_valid && s_ready) begin
        act    <= 1'b1;
        sl     <= '0;
        word_r <= enc_i;
        md_r   <= mode_i;
      end else if (act) begin
        sl <= sl + SW'(1);
        if (sl == LAST) act <= 1'b0;
      end
    end
  end

  // R3 R5
  line_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(line_o) |-> (bclk_o == (lmode == MODE_PLAIN)));
  // R6
  frame_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_o |=> !frame_o);
  // R1
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);
endmodule

// File: rtl/pinv_deserializer.sv
module pinv_deserializer
  import pinv_pkg::*;
#(
  parameter int WL = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_i,
  input  logic          bclk_i,
  input  logic          frame_i,
  output logic          m_valid,
  output logic [WL-1:0] m_data,
  output logic          m_coded
);
  localparam int IW = $clog2(WL);

  logic [WL-1:0] flip;
  logic          busy, skip;
  logic [IW-1:0] idx;
  logic [WL-1:0] sh, full;
  mode_e         md;

  for (genvar g = 0; g < WL; g++) begin : g_flip
    assign flip[g] = (g % 2 == 1);
  end

  always_comb begin
    full      = sh;
    full[idx] = line_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      skip    <= 1'b0;
      idx     <= '0;
      sh      <= '0;
      md      <= MODE_PLAIN;
      m_valid <= 1'b0;
      m_data  <= '0;
      m_coded <= 1'b0;
    end else begin
      m_valid <= 1'b0;
      if (frame_i) begin
        busy <= 1'b1;
        skip <= 1'b1;
        idx  <= IW'(1);
        sh   <= {{(WL-1){1'b0}}, line_i};
        md   <= bclk_i ? MODE_PLAIN : MODE_PAIRINV;
      end else if (busy) begin
        if (skip) begin
          skip <= 1'b0;
        end else begin
          sh   <= full;
          skip <= 1'b1;
          if (idx == IW'(WL - 1)) begin
            busy    <= 1'b0;
            m_valid <= 1'b1;
            m_data  <= (md == MODE_PAIRINV) ? (full ^ flip) : full;
            m_coded <= (md == MODE_PAIRINV);
          end else begin
            idx <= idx + IW'(1);
          end
        end
      end
    end
  end

  // R7
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |=> !m_valid);
  // R8
  rx_realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_i |=> !m_valid);
endmodule

// File: rtl/pinv_link.sv
module pinv_link
  import pinv_pkg::*;
#(
  parameter int WL = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [WL-1:0] s_data,
  output logic          line_o,
  output logic          bclk_o,
  output logic          frame_o,
  input  logic          line_i,
  input  logic          bclk_i,
  input  logic          frame_i,
  output logic          m_valid,
  output logic [WL-1:0] m_data,
  output logic          m_coded
);
  logic [WL-1:0] enc;
  mode_e         mode;

  pinv_encoder #(.WL(WL)) u_enc (
    .raw(s_data), .enc(enc), .mode(mode)
  );

  pinv_serializer #(.WL(WL)) u_tx (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .enc_i(enc), .mode_i(mode), .bclk_o(bclk_o), .line_o(line_o),
    .frame_o(frame_o)
  );

  pinv_deserializer #(.WL(WL)) u_rx (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .bclk_i(bclk_i),
    .frame_i(frame_i), .m_valid(m_valid), .m_data(m_data),
    .m_coded(m_coded)
  );

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!frame_o && !m_valid && !line_o));
endmodule

// File: tb/pinv_link_tb.sv
module pinv_link_tb;
  localparam int WL = 8;
  localparam int NV = 12;
  // {coded, data}; coded when adjacent-bit changes >= 4
  localparam logic [8:0] VEC [NV] = '{
    {1'b0, 8'h00}, {1'b0, 8'hFF}, {1'b1, 8'h55}, {1'b0, 8'h0F},
    {1'b0, 8'h33}, {1'b1, 8'h0A}, {1'b0, 8'h05}, {1'b1, 8'hAA},
    {1'b0, 8'hC3}, {1'b1, 8'h96}, {1'b1, 8'h16}, {1'b0, 8'h02}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic s_valid = 1'b0;
  logic [WL-1:0] s_data = '0;
  logic s_ready, line_o, bclk_o, frame_o, m_valid, m_coded;
  logic [WL-1:0] m_data;
  logic inj = 1'b0, bl = 1'b0, bb = 1'b0, bf = 1'b0;
  logic line_i, bclk_i, frame_i;

  assign line_i  = inj ? bl : line_o;
  assign bclk_i  = inj ? bb : bclk_o;
  assign frame_i = inj ? bf : frame_o;

  always #4 clk = ~clk;

  pinv_link #(.WL(WL)) u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .line_o(line_o), .bclk_o(bclk_o), .frame_o(frame_o),
    .line_i(line_i), .bclk_i(bclk_i), .frame_i(frame_i),
    .m_valid(m_valid), .m_data(m_data), .m_coded(m_coded)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog: actual %0d expected <20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  // line capture monitor
  int nf = 0, cap_t = 0;
  bit cap_on = 1'b0, cap_bclk = 1'b0;
  logic [WL-1:0] cur = '0;
  logic [WL-1:0] cap_line [32];
  logic cap_ph [32];
  int nr = 0;
  logic [WL-1:0] rx_d [32];
  logic rx_c [32];

  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_o) begin
        cap_on = 1'b1; cap_t = 0; cur = '0; cur[0] = line_o; cap_bclk = bclk_o;
      end else if (cap_on) begin
        cap_t++;
        if (cap_t % 2 == 0) cur[cap_t/2] = line_o;
        if (cap_t == 2 * (WL - 1)) begin
          if (nf < 32) begin cap_line[nf] = cur; cap_ph[nf] = cap_bclk; end
          nf++; cap_on = 1'b0;
        end
      end
      if (m_valid) begin
        if (nr < 32) begin rx_d[nr] = m_data; rx_c[nr] = m_coded; end
        nr++;
      end
    end
  end

  int acc [NV];

  task automatic send(input logic [WL-1:0] d, output int t);
    s_valid = 1'b1; s_data = d;
    while (!s_ready) @(negedge clk);
    t = cyc;
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic inj_word(input logic [WL-1:0] lb, input logic hi, input int nb);
    for (int t = 0; t < 2 * nb; t++) begin
      @(negedge clk);
      bf = (t == 0);
      bb = (t % 2 == 0) ? hi : !hi;
      bl = lb[t/2];
    end
    @(negedge clk);
    bf = 1'b0;
  endtask

  initial begin
    int t0, r0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(line_o == 1'b0, "R9 line_o", line_o, 0);
    chk(frame_o == 1'b0 && bclk_o == 1'b0, "R9 frame/bclk", {frame_o, bclk_o}, 0);
    chk(m_valid == 1'b0 && m_coded == 1'b0, "R9 m_valid/m_coded", {m_valid, m_coded}, 0);
    chk(m_data == '0, "R9 m_data", m_data, 0);
    rst_n = 1'b1;

    // table walk, back to back
    for (int i = 0; i < NV; i++) send(VEC[i][7:0], acc[i]);
    chk(s_ready == 1'b0, "R1 ready low after accept", s_ready, 0);
    repeat (40) @(negedge clk);
    chk(nf == NV, "R6 frame count", nf, NV);
    chk(nr == NV, "R7 output count", nr, NV);
    for (int i = 0; i < NV; i++) begin
      logic [WL-1:0] d, el;
      logic c;
      d = VEC[i][7:0]; c = VEC[i][8];
      el = c ? (d ^ 8'hAA) : d;
      chk(cap_line[i] == el, c ? "R4 coded line" : "R3 plain line", cap_line[i], el);
      chk(cap_ph[i] == !c, "R5 frame phase", cap_ph[i], !c);
      chk(rx_c[i] == c, "R2 coded flag", rx_c[i], c);
      chk(rx_d[i] == d, "R7 decoded word", rx_d[i], d);
      if (i > 0) chk(acc[i] - acc[i-1] == 2 * WL, "R1 accept spacing", acc[i] - acc[i-1], 2 * WL);
    end

    // idle gap then a constant-line coded word
    repeat (5) @(negedge clk);
    send(8'h55, t0);
    repeat (40) @(negedge clk);
    chk(nr == NV + 1 && rx_d[NV] == 8'h55, "R7 after idle", rx_d[NV], 8'h55);
    chk(cap_line[NV] == 8'hFF && cap_ph[NV] == 1'b0, "R4 R5 constant coded", cap_line[NV], 8'hFF);

    // R8 realign: truncated frame then full coded and plain frames
    r0 = nr;
    inj = 1'b1;
    inj_word(8'hFF, 1'b1, 3);
    inj_word(8'hA0, 1'b0, WL);
    repeat (4) @(negedge clk);
    chk(nr == r0 + 1, "R8 partial word dropped", nr - r0, 1);
    chk(rx_d[r0] == 8'h0A && rx_c[r0] == 1'b1, "R8 realigned coded word", rx_d[r0], 8'h0A);
    inj_word(8'hC3, 1'b1, WL);
    repeat (4) @(negedge clk);
    chk(nr == r0 + 2 && rx_d[r0+1] == 8'hC3 && rx_c[r0+1] == 1'b0, "R7 injected plain", rx_d[r0+1], 8'hC3);
    inj = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule